// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs one external data-memory transfer at a time on an 8051-style multiplexed bus. The core hands it a request: direction, a 16-bit address and, for a write, a data byte. The block then runs a fixed-length cycle, with every edge placed by counting input clocks. It first pulses the address latch strobe while the low address byte sits on port 0. It then drives the active-low read or write strobe. Finally it either drives the write byte or captures the read byte from port 0. Port 2 carries the high address byte for the whole cycle.

The core sees a pulse-style handshake. It raises a request for one clock. One clock after that cycle's strobe rises, the block pulses its acknowledge for one clock, and read data is valid in that clock. A single holding slot keeps one request that arrives while a cycle is running. That request starts as soon as the running cycle finishes. The default phase lengths are: latch strobe high 2 clocks, 3 clocks from its fall to the strobe fall, strobe low 6 clocks, and 1 recovery clock. A cycle is therefore 12 clocks long. All of these lengths are parameters.

Top module: `xbus_seq`

## Requirements
- R1: Out of reset and between cycles, `ale_o` is 0, `rd_n_o` and `wr_n_o` are 1, `p0_oe_o` and `ack_o` are 0, and `p2_out_o` shows the idle value (8'hFF by default).
- R2: A cycle begins with `ale_o` high for ALE_HI clocks (2). The low address byte is driven on port 0 (`p0_oe_o`=1, `p0_out_o`=addr[7:0]) from the first `ale_o`-high clock through the one clock that follows the fall of `ale_o`.
- R3: The strobe that matches the direction (`rd_n_o` for `req_wr_i`=0, `wr_n_o` for `req_wr_i`=1) goes low STB_DLY clocks (3) after `ale_o` falls and stays low for exactly STB_W clocks (6). The other strobe stays high, and the strobe is never low while `ale_o` is high.
- R4: In a write, port 0 drives the write byte from one clock before `wr_n_o` falls through the clock after it rises. Port 0 is released between the address hold clock and that first data clock.
- R5: In a read, port 0 stays released from the end of the address hold until the end of the cycle. `p0_in_i` is captured at the clock edge that ends the last strobe-low clock, and that byte is shown on `rdata_o` during the acknowledge.
- R6: `p2_out_o` equals addr[15:8] in every clock of a cycle.
- R7: `ack_o` is high for exactly one clock, the clock right after the strobe rises. Both strobes are high and `ale_o` is low during it.
- R8: A request that arrives while a cycle runs is held. Its cycle starts with `ale_o` high in the clock right after the running cycle's acknowledge.
- R9: A request that arrives while another request is already held, and that held request is not launching in that clock, is ignored and never produces a cycle.
- R10: From idle, a request sampled at one clock edge makes `ale_o` go high after the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every bus timing is a count of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-clock transfer request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 8 | Write byte |
| ack_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | 8 | Read byte, valid with ack_o |
| ale_o | output | 1 | Address latch strobe, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| p0_out_o | output | 8 | Port 0 drive value (address low byte or write byte) |
| p0_oe_o | output | 1 | Port 0 output enable |
| p0_in_i | input | 8 | Port 0 input value |
| p2_out_o | output | 8 | Port 2 value (address high byte) |

## Verification
A phase counter that slips by one clock moves a strobe or the latch edge in that same clock. The pin checks, run every clock, catch this in the first cycle it affects. A wrong capture point shows up as a bad `rdata_o` at the acknowledge, because the bench presents the correct byte only during the last half clock before the capture edge. A slot that loses or duplicates a request shows up either as a missing back-to-back latch pulse in the clock after the acknowledge, or as a cycle that appears when no request is expected.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      XPH_IDLE  = 3'd0,
      XPH_ALE   = 3'd1,
      XPH_GAP   = 3'd2,
      XPH_STB   = 3'd3,
      XPH_RECOV = 3'd4
   } xbus_phase_e;

   function automatic int xbus_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/xbus_req_slot.sv
module xbus_req_slot #(
   parameter int CMD_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic             take_i,
   output logic             vld_o,
   output logic [CMD_W-1:0] cmd_o
);

   logic             vld_q;
   logic [CMD_W-1:0] cmd_q;
   logic             accept;

   // Room exists when empty or when the held entry leaves this clock.
   assign accept = req_i && (!vld_q || take_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         cmd_q <= '0;
      end else begin
         if (accept) begin
            vld_q <= 1'b1;
            cmd_q <= cmd_i;
         end else if (take_i) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign vld_o = vld_q;
   assign cmd_o = cmd_q;

endmodule

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer
   import xbus_pkg::*;
#(
   parameter int ALE_HI  = 2,
   parameter int STB_DLY = 3,
   parameter int STB_W   = 6,
   parameter int CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output xbus_phase_e      phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             can_start_o
);

   localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_HI - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(STB_DLY - 1);
   localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_W - 1);

   xbus_phase_e      phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q + CNT_W'(1);
      unique case (phase_q)
         XPH_IDLE: begin
            cnt_d = '0;
            if (start_i) phase_d = XPH_ALE;
         end
         XPH_ALE: begin
            if (cnt_q == ALE_LAST) begin
               phase_d = XPH_GAP;
               cnt_d   = '0;
            end
         end
         XPH_GAP: begin
            if (cnt_q == GAP_LAST) begin
               phase_d = XPH_STB;
               cnt_d   = '0;
            end
         end
         XPH_STB: begin
            if (cnt_q == STB_LAST) begin
               phase_d = XPH_RECOV;
               cnt_d   = '0;
            end
         end
         XPH_RECOV: begin
            cnt_d   = '0;
            phase_d = start_i ? XPH_ALE : XPH_IDLE;
         end
         default: begin
            phase_d = XPH_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= XPH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase_o     = phase_q;
   assign cnt_o       = cnt_q;
   assign can_start_o = (phase_q == XPH_IDLE) || (phase_q == XPH_RECOV);

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
   import xbus_pkg::*;
#(
   parameter int                BYTE_W       = 8,
   parameter int                STB_DLY      = 3,
   parameter int                STB_W        = 6,
   parameter int                CNT_W        = 3,
   parameter bit                P2_HOLD_IDLE = 1'b0,
   parameter logic [BYTE_W-1:0] P2_IDLE      = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                cmd_wr_i,
   input  logic [2*BYTE_W-1:0] cmd_addr_i,
   input  logic [BYTE_W-1:0]   cmd_wdata_i,
   input  xbus_phase_e         phase_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  logic [BYTE_W-1:0]   p0_in_i,
   output logic                ale_o,
   output logic                rd_n_o,
   output logic                wr_n_o,
   output logic [BYTE_W-1:0]   p0_out_o,
   output logic                p0_oe_o,
   output logic [BYTE_W-1:0]   p2_out_o,
   output logic                ack_o,
   output logic [BYTE_W-1:0]   rdata_o
);

   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(STB_DLY - 1);
   localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_W - 1);

   logic                act_wr_q;
   logic [2*BYTE_W-1:0] act_addr_q;
   logic [BYTE_W-1:0]   act_wdata_q;
   logic [BYTE_W-1:0]   rdata_q;

   logic in_cycle, addr_drv, data_drv, stb_on, capture;

   // The active command changes only at launch; a back-to-back launch
   // takes effect on the same edge that leaves recovery.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_wr_q    <= 1'b0;
         act_addr_q  <= '0;
         act_wdata_q <= '0;
      end else if (start_i) begin
         act_wr_q    <= cmd_wr_i;
         act_addr_q  <= cmd_addr_i;
         act_wdata_q <= cmd_wdata_i;
      end
   end

   assign in_cycle = (phase_i != XPH_IDLE);
   assign stb_on   = (phase_i == XPH_STB);
   assign addr_drv = (phase_i == XPH_ALE) ||
                     ((phase_i == XPH_GAP) && (cnt_i == '0));
   assign data_drv = act_wr_q &&
                     (((phase_i == XPH_GAP) && (cnt_i == GAP_LAST)) ||
                      stb_on || (phase_i == XPH_RECOV));
   assign capture  = stb_on && !act_wr_q && (cnt_i == STB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= p0_in_i;
   end

   assign ale_o    = (phase_i == XPH_ALE);
   assign rd_n_o   = !(stb_on && !act_wr_q);
   assign wr_n_o   = !(stb_on && act_wr_q);
   assign p0_oe_o  = addr_drv || data_drv;
   assign p0_out_o = addr_drv ? act_addr_q[BYTE_W-1:0] :
                     data_drv ? act_wdata_q : '0;
   assign ack_o    = (phase_i == XPH_RECOV);
   assign rdata_o  = rdata_q;

   generate
      if (P2_HOLD_IDLE) begin : g_p2_hold
         assign p2_out_o = act_addr_q[2*BYTE_W-1:BYTE_W];
      end else begin : g_p2_park
         assign p2_out_o = in_cycle ? act_addr_q[2*BYTE_W-1:BYTE_W] : P2_IDLE;
      end
   endgenerate

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int                BYTE_W       = 8,
   parameter int                ALE_HI       = 2,
   parameter int                STB_DLY      = 3,
   parameter int                STB_W        = 6,
   parameter bit                P2_HOLD_IDLE = 1'b0,
   parameter logic [BYTE_W-1:0] P2_IDLE      = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic                req_wr_i,
   input  logic [2*BYTE_W-1:0] req_addr_i,
   input  logic [BYTE_W-1:0]   req_wdata_i,
   output logic                ack_o,
   output logic [BYTE_W-1:0]   rdata_o,
   output logic                ale_o,
   output logic                rd_n_o,
   output logic                wr_n_o,
   output logic [BYTE_W-1:0]   p0_out_o,
   output logic                p0_oe_o,
   input  logic [BYTE_W-1:0]   p0_in_i,
   output logic [BYTE_W-1:0]   p2_out_o
);

   localparam int ADDR_W = 2 * BYTE_W;
   localparam int CMD_W  = 1 + ADDR_W + BYTE_W;
   localparam int MAXLEN = xbus_max3(ALE_HI, STB_DLY, STB_W);
   localparam int CNT_W  = $clog2(MAXLEN + 1);

   generate
      if (BYTE_W < 1)  begin : g_bad_byte $error("BYTE_W must be at least 1"); end
      if (ALE_HI < 1)  begin : g_bad_ale  $error("ALE_HI must be at least 1"); end
      if (STB_DLY < 2) begin : g_bad_dly  $error("STB_DLY must be at least 2"); end
      if (STB_W < 1)   begin : g_bad_stb  $error("STB_W must be at least 1"); end
   endgenerate

   logic              slot_vld, can_start, start;
   logic [CMD_W-1:0]  slot_cmd;
   xbus_phase_e       phase;
   logic [CNT_W-1:0]  cnt;

   assign start = slot_vld && can_start;

   xbus_req_slot #(.CMD_W(CMD_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .cmd_i  ({req_wr_i, req_addr_i, req_wdata_i}),
      .take_i (start),
      .vld_o  (slot_vld),
      .cmd_o  (slot_cmd)
   );

   xbus_phase_timer #(
      .ALE_HI (ALE_HI),
      .STB_DLY(STB_DLY),
      .STB_W  (STB_W),
      .CNT_W  (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .phase_o    (phase),
      .cnt_o      (cnt),
      .can_start_o(can_start)
   );

   xbus_pin_drive #(
      .BYTE_W      (BYTE_W),
      .STB_DLY     (STB_DLY),
      .STB_W       (STB_W),
      .CNT_W       (CNT_W),
      .P2_HOLD_IDLE(P2_HOLD_IDLE),
      .P2_IDLE     (P2_IDLE)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .cmd_wr_i   (slot_cmd[CMD_W-1]),
      .cmd_addr_i (slot_cmd[CMD_W-2:BYTE_W]),
      .cmd_wdata_i(slot_cmd[BYTE_W-1:0]),
      .phase_i    (phase),
      .cnt_i      (cnt),
      .p0_in_i    (p0_in_i),
      .ale_o      (ale_o),
      .rd_n_o     (rd_n_o),
      .wr_n_o     (wr_n_o),
      .p0_out_o   (p0_out_o),
      .p0_oe_o    (p0_oe_o),
      .p2_out_o   (p2_out_o),
      .ack_o      (ack_o),
      .rdata_o    (rdata_o)
   );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
   parameter int STB_W = 6
) (
   input logic clk,
   input logic rst_n,
   input logic ale_o,
   input logic rd_n_o,
   input logic wr_n_o,
   input logic p0_oe_o,
   input logic ack_o
);

   localparam int RUN_W = $clog2(STB_W + 2);

   logic             stb_low, prev_low_q;
   logic [RUN_W-1:0] run_q;

   assign stb_low = !rd_n_o || !wr_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_low_q <= 1'b0;
         run_q      <= '0;
      end else begin
         prev_low_q <= stb_low;
         run_q      <= stb_low ? run_q + RUN_W'(1) : '0;
      end
   end

   assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_low_q && !stb_low) |-> (run_q == RUN_W'(STB_W)));

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));

   assert_no_strobe_in_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_low |-> !ale_o);

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale_o) |-> p0_oe_o);

   assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> p0_oe_o);

   assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !p0_oe_o);

   assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   assert_ack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (rd_n_o && wr_n_o && !ale_o));

endmodule

bind xbus_seq xbus_seq_chk #(.STB_W(STB_W)) u_xbus_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ale_o  (ale_o),
   .rd_n_o (rd_n_o),
   .wr_n_o (wr_n_o),
   .p0_oe_o(p0_oe_o),
   .ack_o  (ack_o)
);

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;

   localparam int A_HI = 2;
   localparam int DLY  = 3;
   localparam int SW   = 6;
   localparam int LEN  = A_HI + DLY + SW + 1;
   localparam int STB0 = A_HI + DLY;
   localparam int STBL = A_HI + DLY + SW - 1;

   typedef struct {
      bit         wr;
      logic [15:0] addr;
      logic [7:0]  wdata;
      logic [7:0]  resp;
      bit         b2b;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        req_wr_i = 1'b0;
   logic [15:0] req_addr_i = '0;
   logic [7:0]  req_wdata_i = '0;
   logic [7:0]  p0_in = '0;
   logic        ack_o, ale_o, rd_n_o, wr_n_o, p0_oe_o;
   logic [7:0]  rdata_o, p0_out_o, p2_out_o;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   int    mon_t = -1;
   bit    expect_b2b = 1'b0;
   item_t exp_q[$];
   item_t cur;

   always #2 clk = ~clk;

   xbus_seq #(
      .BYTE_W(8), .ALE_HI(A_HI), .STB_DLY(DLY), .STB_W(SW),
      .P2_HOLD_IDLE(1'b0), .P2_IDLE(8'hFF)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_wr_i(req_wr_i),
      .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
      .ack_o(ack_o), .rdata_o(rdata_o), .ale_o(ale_o),
      .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .p0_out_o(p0_out_o),
      .p0_oe_o(p0_oe_o), .p0_in_i(p0_in), .p2_out_o(p2_out_o)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic issue(input bit wr, input logic [15:0] addr,
                        input logic [7:0] wd, input logic [7:0] resp,
                        input bit b2b, input bit expect_run);
      item_t it;
      @(negedge clk);
      if (expect_run) begin
         it.wr = wr; it.addr = addr; it.wdata = wd; it.resp = resp; it.b2b = b2b;
         exp_q.push_back(it);
      end
      req_i = 1'b1; req_wr_i = wr; req_addr_i = addr; req_wdata_i = wd;
      @(negedge clk);
      req_i = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (exp_q.size() != 0 || mon_t >= 0);
      repeat (3) @(negedge clk);
   endtask

   // Monitor: pops an expected item at each ALE rise, checks every clock.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (mon_t < 0) begin
               if (expect_b2b) begin
                  check(ale_o, "R8", "held cycle ALE right after ack", ale_o, 1);
                  expect_b2b = 1'b0;
               end
               if (ale_o) begin
                  if (exp_q.size() == 0) begin
                     check(1'b0, "R9", "cycle with no expected request", 1, 0);
                  end else begin
                     cur   = exp_q.pop_front();
                     mon_t = 0;
                  end
               end else begin
                  check(rd_n_o && wr_n_o && !p0_oe_o && !ack_o, "R1",
                        "idle rd_n/wr_n/oe/ack", {rd_n_o, wr_n_o, p0_oe_o, ack_o}, 4'b1100);
                  check(p2_out_o == 8'hFF, "R1", "idle port 2", p2_out_o, 8'hFF);
               end
            end
            if (mon_t >= 0) begin
               automatic int  t      = mon_t;
               automatic bit  e_ale  = (t < A_HI);
               automatic bit  e_addr = (t <= A_HI);
               automatic bit  e_stb  = (t >= STB0) && (t <= STBL);
               automatic bit  e_dat  = cur.wr && (t >= STB0 - 1);
               automatic bit  e_oe   = e_addr || e_dat;
               automatic logic [7:0] e_p0 = e_addr ? cur.addr[7:0] : cur.wdata;
               if (t == 0) p0_in = ~cur.resp;
               if (t == STBL) p0_in = cur.resp;
               check(ale_o == e_ale, "R2", $sformatf("ale at t=%0d", t), ale_o, e_ale);
               check(rd_n_o == !(e_stb && !cur.wr), "R3", $sformatf("rd_n at t=%0d", t),
                     rd_n_o, !(e_stb && !cur.wr));
               check(wr_n_o == !(e_stb && cur.wr), "R3", $sformatf("wr_n at t=%0d", t),
                     wr_n_o, !(e_stb && cur.wr));
               if (cur.wr)
                  check(p0_oe_o == e_oe, "R4", $sformatf("write p0 oe at t=%0d", t), p0_oe_o, e_oe);
               else
                  check(p0_oe_o == e_oe, "R5", $sformatf("read p0 oe at t=%0d", t), p0_oe_o, e_oe);
               if (e_oe)
                  check(p0_out_o == e_p0, e_addr ? "R2" : "R4",
                        $sformatf("p0 value at t=%0d", t), p0_out_o, e_p0);
               check(p2_out_o == cur.addr[15:8], "R6", $sformatf("p2 at t=%0d", t),
                     p2_out_o, cur.addr[15:8]);
               check(ack_o == (t == LEN - 1), "R7", $sformatf("ack at t=%0d", t),
                     ack_o, (t == LEN - 1));
               if (t == LEN - 1) begin
                  if (!cur.wr)
                     check(rdata_o == cur.resp, "R5", "read byte with ack", rdata_o, cur.resp);
                  p0_in      = ~cur.resp;
                  mon_t      = -1;
                  expect_b2b = (exp_q.size() > 0) && exp_q[0].b2b;
               end else begin
                  mon_t = t + 1;
               end
            end
         end
      end
   end

   // Driver
   initial begin
      repeat (3) @(negedge clk);
      check(!ale_o && rd_n_o && wr_n_o && !p0_oe_o && !ack_o, "R1", "pins in reset",
            {ale_o, rd_n_o, wr_n_o, p0_oe_o, ack_o}, 5'b01100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: latency from idle
      @(negedge clk);
      begin
         item_t it;
         it.wr = 1'b0; it.addr = 16'h1234; it.wdata = 8'h00; it.resp = 8'h5A; it.b2b = 1'b0;
         exp_q.push_back(it);
      end
      req_i = 1'b1; req_wr_i = 1'b0; req_addr_i = 16'h1234; req_wdata_i = 8'h00;
      @(negedge clk);
      req_i = 1'b0;
      check(!ale_o, "R10", "ale one edge after sampling", ale_o, 0);
      @(negedge clk);
      check(ale_o, "R10", "ale two edges after sampling", ale_o, 1);
      wait_idle();

      issue(1'b1, 16'h00FF, 8'hA5, 8'h00, 1'b0, 1'b1);
      wait_idle();
      issue(1'b1, 16'hFF00, 8'h3C, 8'h00, 1'b0, 1'b1);
      wait_idle();
      issue(1'b0, 16'hFFFF, 8'h00, 8'hC3, 1'b0, 1'b1);
      wait_idle();
      issue(1'b0, 16'h0000, 8'h00, 8'h81, 1'b0, 1'b1);
      wait_idle();

      // R8 and R9: held request, then one dropped while the slot is full
      issue(1'b1, 16'hBEEF, 8'h96, 8'h00, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      issue(1'b0, 16'h0102, 8'h00, 8'h7E, 1'b1, 1'b1);
      repeat (1) @(negedge clk);
      issue(1'b1, 16'hDEAD, 8'h11, 8'h00, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      issue(1'b1, 16'hA55A, 8'hE7, 8'h00, 1'b1, 1'b1);
      wait_idle();
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0 && mon_t < 0, "R9", "no cycle left after drop",
            exp_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule